// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 pad lines. Every line owns an 8-bit control byte, held in a 32-bit register slot, that decides whether the line drives its pad, whether its input is observed, and whether and how it raises an interrupt. The interrupt trigger can be a high or low level, a rising or falling edge, or any edge.

Pad inputs pass through a two-flop synchroniser before any detection logic sees them. A single status register latches one pending bit per line. Software clears these bits by writing ones to them. The pending bits, gated by each line's interrupt enable, drive a per-line interrupt vector and a single OR-reduced interrupt output. A downstream interrupt router can use either one.

Register access uses a plain write strobe with an address and write data. Read data is combinational from the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every control byte and every pending bit. While reset is held, and in the cycle after it, irq_vec, irq_any, pad_out and pad_oe are all zero.
- R2: The control register of line i sits at byte offset 4*i. It stores write-data bits [7:0] and reads them back with bits [31:8] as zero. The fields are: bit 0 output enable, bit 1 input enable, bit 2 output buffer enable, bit 3 interrupt enable, bit 4 output value, and bits [7:5] trigger type.
- R3: pad_oe[i] equals bit 0 AND bit 2 of line i's control byte. pad_out[i] equals bit 0 AND bit 4 of that byte.
- R4: Each pad input is synchronised by two flops. A read at offset 0x84 returns the synchronised inputs AND-ed with each line's input enable, so a pad change becomes visible two clock edges later.
- R5: Trigger code 000 (level high) and code 001 (level low) set the line's pending bit on every cycle in which the synchronised level matches. This only happens when both the input enable and the interrupt enable are 1.
- R6: Code 010 sets the pending bit on a rising edge, code 011 on a falling edge, and code 100 on either edge. An edge is detected by comparing the synchronised value with its previous sample. The pending bit is visible three clock edges after the pad changes.
- R7: Trigger codes 101, 110 and 111 never set a pending bit.
- R8: The status register sits at offset 0x80 and reads back the pending bits AND-ed with the interrupt enables. Writing to it clears exactly the bits written as 1. In the write cycle the clear wins over a new event, so an active level sets its bit again one cycle later.
- R9: Clearing a line's interrupt enable stops new pending events for that line and hides its pending bit from the outputs and from the status read. The line's other control bits are left unchanged.
- R10: irq_vec equals the status read value, bit for bit. irq_any is 1 exactly when any bit of irq_vec is 1.
- R11: The following are ignored and read as zero: writes and reads at unaligned offsets below 0x80, at offsets of lines at or beyond NUM_LINES, and at any offset other than 0x80 and 0x84 from 0x80 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | NUM_LINES | Asynchronous pad inputs |
| pad_out | output | NUM_LINES | Pad output values |
| pad_oe | output | NUM_LINES | Pad output buffer enables |
| irq_vec | output | NUM_LINES | Per-line interrupt vector |
| irq_any | output | 1 | OR of all line interrupts |

## Verification
The bound checker watches four behaviours on every cycle:
- the interrupt outputs are quiet after reset;
- the clear-on-write hides cleared lines in the following cycle;
- pad drive holds steady when no write occurs;
- irq_any agrees with the status read whenever the status offset is addressed.

Only the bench's scenarios can show the trigger decoding for each of the five codes and the three unused codes, the two- and three-edge input latency, the re-assertion of a held level after a clear, and the masking done by the interrupt enable. The bench does this by running a cycle model alongside directed and random traffic.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wen,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic [NUM_LINES-1:0] irq_vec,
  output logic                 irq_any
);
  localparam int STAT_OFS = 'h80;
  localparam int IN_OFS   = 'h84;
  localparam int CTRL_END = 4 * NUM_LINES;
  localparam int IDX_W    = ADDR_W - 2;

  logic [7:0]           ctrl [NUM_LINES];
  logic [NUM_LINES-1:0] sync1, sync2, prev, pend, ev, irq_en, in_en;
  logic [IDX_W-1:0]     idx;
  logic                 ctrl_sel, stat_sel, in_sel;
  logic [NUM_LINES-1:0] clr;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign ctrl_sel = (int'(bus_addr) < CTRL_END) && (bus_addr[1:0] == 2'b00);
  assign stat_sel = (int'(bus_addr) == STAT_OFS);
  assign in_sel   = (int'(bus_addr) == IN_OFS);
  assign clr      = (bus_wen && stat_sel) ? bus_wdata[NUM_LINES-1:0] : '0;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit;
    assign irq_en[i]  = ctrl[i][3];
    assign in_en[i]   = ctrl[i][1];
    assign pad_oe[i]  = ctrl[i][0] & ctrl[i][2];
    assign pad_out[i] = ctrl[i][0] & ctrl[i][4];

    always_comb begin
      case (ctrl[i][7:5])
        3'd0:    hit = sync2[i];
        3'd1:    hit = ~sync2[i];
        3'd2:    hit = sync2[i] & ~prev[i];
        3'd3:    hit = ~sync2[i] & prev[i];
        3'd4:    hit = sync2[i] ^ prev[i];
        default: hit = 1'b0;
      endcase
    end
    assign ev[i] = hit & irq_en[i] & in_en[i];

    always_ff @(posedge clk) begin
      if (rst)
        ctrl[i] <= '0;
      else if (bus_wen && ctrl_sel && (int'(idx) == i))
        ctrl[i] <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      pend  <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      prev  <= sync2;
      pend  <= (pend | ev) & ~clr;
    end
  end

  assign irq_vec = pend & irq_en;
  assign irq_any = |irq_vec;

  always_comb begin
    bus_rdata = '0;
    if (stat_sel)
      bus_rdata[NUM_LINES-1:0] = irq_vec;
    else if (in_sel)
      bus_rdata[NUM_LINES-1:0] = sync2 & in_en;
    else if (ctrl_sel)
      bus_rdata[7:0] = ctrl[idx];
  end
endmodule

module gpio_irq_ctrl_chk #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wen,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] pad_out,
  input logic [NUM_LINES-1:0] pad_oe,
  input logic [NUM_LINES-1:0] irq_vec,
  input logic                 irq_any
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (irq_vec == '0 && !irq_any && pad_oe == '0)); // R1
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && int'(bus_addr) == 'h80) |=> ((irq_vec & $past(bus_wdata[NUM_LINES-1:0])) == '0)); // R8
  AST_PAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_wen |=> ($stable(pad_out) && $stable(pad_oe))); // R3
  AST_ANY_MATCHES_STATUS: assert property (@(posedge clk) disable iff (rst)
    (int'(bus_addr) == 'h80) |-> ((bus_rdata != 32'd0) == irq_any)); // R10
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  localparam int N = 32;
  logic clk = 0, rst = 1, bus_wen = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] pad_in = 0, pad_out, pad_oe, irq_vec;
  logic irq_any;

  gpio_irq_ctrl #(.NUM_LINES(N), .ADDR_W(8)) dut (.*);

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  logic [7:0] m_ctrl [N];
  logic [N-1:0] m_s1, m_s2, m_prev, m_pend;

  function automatic logic [N-1:0] m_en();
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) e[i] = m_ctrl[i][3];
    return e;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r = 0;
    if (a == 8'h80) r = m_pend & m_en();
    else if (a == 8'h84) begin
      for (int i = 0; i < N; i++) r[i] = m_s2[i] & m_ctrl[i][1];
    end else if (a < 8'h80 && a[1:0] == 0) r = {24'd0, m_ctrl[a[7:2]]};
    return r;
  endfunction

  function automatic logic trig(input logic [2:0] t, input logic s, input logic p);
    case (t)
      3'd0: return s;
      3'd1: return !s;
      3'd2: return s && !p;
      3'd3: return !s && p;
      3'd4: return s != p;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_step();
    logic [N-1:0] ev, clr;
    if (rst) begin
      for (int i = 0; i < N; i++) m_ctrl[i] = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
      return;
    end
    for (int i = 0; i < N; i++)
      ev[i] = trig(m_ctrl[i][7:5], m_s2[i], m_prev[i]) && m_ctrl[i][3] && m_ctrl[i][1];
    clr = (bus_wen && bus_addr == 8'h80) ? bus_wdata : 0;
    m_pend = (m_pend | ev) & ~clr;
    if (bus_wen && bus_addr < 8'h80 && bus_addr[1:0] == 0) m_ctrl[bus_addr[7:2]] = bus_wdata[7:0];
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
  endtask

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [N-1:0] oe, po;
    for (int i = 0; i < N; i++) begin
      oe[i] = m_ctrl[i][0] & m_ctrl[i][2];
      po[i] = m_ctrl[i][0] & m_ctrl[i][4];
    end
    cmp("irq_vec (R10)", irq_vec, m_pend & m_en());
    cmp("irq_any (R10)", {31'd0, irq_any}, {31'd0, |(m_pend & m_en())});
    cmp("pad_oe (R3)", pad_oe, oe);
    cmp("pad_out (R3)", pad_out, po);
    cmp("rdata (R2/R8)", bus_rdata, m_read(bus_addr));
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [N-1:0] p);
    bus_wen = w; bus_addr = a; bus_wdata = d; pad_in = p;
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp);
    step(0, a, 0, pad_in);
    cmp("directed read", bus_rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    tag = "R1";
    for (int k = 0; k < 3; k++) step(0, 8'h80, 0, '1);
    rst = 0;
    expect_rd(8'h80, 0);
    expect_rd(8'h00, 0);
    // R2 control readback, upper bits dropped
    tag = "R2";
    step(1, 8'h7C, 32'hFFFF_FFA5, 0);
    expect_rd(8'h7C, 32'h0000_00A5);
    // R3 pad drive: line 5 out_en, buf_en, value
    tag = "R3";
    step(1, 8'h14, 32'h15, 0);
    step(0, 8'h14, 0, 0);
    cmp("R3 pad_oe[5]", {31'd0, pad_oe[5]}, 1);
    cmp("R3 pad_out[5]", {31'd0, pad_out[5]}, 1);
    // R4 input sync on line 3
    tag = "R4";
    step(1, 8'h0C, 32'h02, 0);
    step(0, 8'h84, 0, 32'h8);
    cmp("R4 one edge later", bus_rdata, 0);
    step(0, 8'h84, 0, 32'h8);
    cmp("R4 two edges later", bus_rdata, 32'h8);
    // R5 level high on line 0
    tag = "R5";
    step(1, 8'h00, 32'h0A, 32'h9);
    step(0, 8'h80, 0, 32'h9);
    step(0, 8'h80, 0, 32'h9);
    step(0, 8'h80, 0, 32'h9);
    cmp("R5 level high pending", bus_rdata[0], 1);
    // R8 clear wins this cycle, level sets again next
    tag = "R8";
    step(1, 8'h80, 32'h1, 32'h9);
    cmp("R8 cleared", irq_vec[0], 0);
    step(0, 8'h80, 0, 32'h9);
    cmp("R8 level re-set", irq_vec[0], 1);
    // R9 disable hides line 0, keeps other bits
    tag = "R9";
    step(1, 8'h00, 32'h02, 32'h9);
    expect_rd(8'h80, 0);
    expect_rd(8'h00, 32'h02);
    // R6 rising on line 1, falling on 2, both on 3
    tag = "R6";
    step(1, 8'h04, 32'h4A, 0);
    step(1, 8'h08, 32'h6A, 32'h4);
    step(1, 8'h0C, 32'h8A, 32'h4);
    step(1, 8'h80, 32'hF, 32'h4);
    step(0, 8'h80, 0, 32'h2);
    step(0, 8'h80, 0, 32'h2);
    step(0, 8'h80, 0, 32'h2);
    cmp("R6 rising line1", bus_rdata[1], 1);
    cmp("R6 falling line2", bus_rdata[2], 1);
    // R7 unused code 101 on line 4 with toggling input
    tag = "R7";
    step(1, 8'h10, 32'hAA, 0);
    for (int k = 0; k < 6; k++) step(0, 8'h80, 0, (k % 2) ? 32'h10 : 0);
    cmp("R7 no pending", bus_rdata[4], 0);
    // R11 unaligned and unmapped offsets
    tag = "R11";
    step(1, 8'h05, 32'hFF, 0);
    step(1, 8'h88, 32'hFF, 0);
    expect_rd(8'h04, 32'h4A);
    expect_rd(8'h88, 0);
    // random traffic
    tag = "RAND R5 R6 R8 R9";
    void'($urandom(32'h5EED));
    for (int k = 0; k < 4000; k++) begin
      int sel = $urandom % 8;
      logic [N-1:0] p = ($urandom % 4 == 0) ? pad_in ^ (32'd1 << ($urandom % N)) : pad_in;
      if (sel < 2) step(1, 8'(($urandom % N) * 4), $urandom, p);
      else if (sel == 2) step(1, 8'h80, $urandom, p);
      else if (sel == 3) step(0, 8'h84, 0, p);
      else if (sel == 4) step(0, 8'(($urandom % N) * 4), 0, p);
      else step(0, 8'h80, 0, p);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule